// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit turns a data-operand addressing request into a physical memory address for a real-mode style segmented machine. A request names an addressing form, selects which pointer registers take part, supplies a short or full displacement, and carries the current pointer and segment register values. The unit adds the chosen terms into a 16-bit offset, picks the segment register (the stack segment when the base pointer is involved, the data segment otherwise, or an explicit override), and forms the physical address as the segment value times sixteen plus the offset.

The result is registered: a request accepted on one clock edge appears on the outputs, with a valid strobe, right after that edge. With no request the outputs keep their last value. Reserved form codes are dropped without any output.

Top module: `seg_ea_gen`

## Requirements
- R1: `out_phys` equals (`out_seg_val` × 16 + `out_offset`) truncated to 20 bits, so FFFFh:FFFFh gives 0FFEFh.
- R2: Form code 0 (direct) uses the extended displacement alone as the offset and, without an override, the data segment (segment code 2).
- R3: Form code 1 (single pointer) uses exactly one pointer register as the offset, chosen by `in_reg_sel`: 0 = BX, 1 = BP, 2 = SI, 3 = DI.
- R4: Form code 2 (base plus index) adds a base and an index register: `in_reg_sel[1]` picks the base (0 = BX, 1 = BP) and `in_reg_sel[0]` the index (0 = SI, 1 = DI).
- R5: Form code 3 (pointer relative) adds the extended displacement to the pointer register chosen as in R3; DS=0200h, BX=0100h, displacement 1000h gives offset 1100h and physical 03100h.
- R6: Form code 4 (base relative plus index) adds the base and index of R4 and the extended displacement.
- R7: Without an override the segment is the stack segment (code 1) whenever BP is the chosen single pointer or the chosen base; otherwise it is the data segment (code 2).
- R8: When `in_disp_short` is 1 only `in_disp[7:0]` is used, sign-extended to 16 bits.
- R9: The offset sum wraps modulo 2^16 before the segment is added.
- R10: With `in_ovr_en` = 1 and `in_ovr_seg` in {0 = ES, 1 = SS, 2 = DS} that segment replaces the default; override code 3 is ignored and the default of R7 is kept.
- R11: Form codes 5, 6 and 7 are reserved: such a request raises no `out_valid` and leaves the outputs unchanged.
- R12: A request with `in_valid` high gives `out_valid` high in the following cycle only; with no accepted request the output values hold.
- R13: After synchronous reset `out_valid`, `out_offset`, `out_seg`, `out_seg_val` and `out_phys` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 3 | Addressing form code (0..4, 5..7 reserved) |
| in_reg_sel | input | 2 | Pointer selection, meaning per form |
| in_disp | input | 16 | Displacement |
| in_disp_short | input | 1 | 1: use sign-extended low byte of displacement |
| in_bx | input | 16 | BX value |
| in_bp | input | 16 | BP value |
| in_si | input | 16 | SI value |
| in_di | input | 16 | DI value |
| in_ds | input | 16 | Data segment value |
| in_ss | input | 16 | Stack segment value |
| in_es | input | 16 | Extra segment value |
| in_ovr_en | input | 1 | Segment override present |
| in_ovr_seg | input | 2 | Override segment code (0 ES, 1 SS, 2 DS, 3 ignored) |
| out_valid | output | 1 | Result strobe |
| out_offset | output | 16 | Offset of the operand |
| out_seg | output | 2 | Segment used (0 ES, 1 SS, 2 DS) |
| out_seg_val | output | 16 | Value of the segment used |
| out_phys | output | 20 | Physical address |

## Verification
A wrong term selection or a lost sign extension shows as a wrong `out_offset` and `out_phys` in the very cycle after the request, so every request is scored against an independently computed offset, segment code and physical address. A wrong default or override decision shows as a wrong `out_seg` and a physical address shifted by a segment difference, again in the next cycle. A fault in the output register shows either as a strobe appearing for a reserved code, a strobe lasting longer than one cycle, or outputs drifting while idle inputs are scrambled, which the bench watches across several idle cycles.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT       = 3'd0,
        AM_REG_IND      = 3'd1,
        AM_BASE_IDX     = 3'd2,
        AM_REG_REL      = 3'd3,
        AM_BASE_REL_IDX = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        SEG_ES   = 2'd0,
        SEG_SS   = 2'd1,
        SEG_DS   = 2'd2,
        SEG_RSVD = 2'd3
    } seg_e;

    // Pointer codes for single-register forms
    localparam logic [1:0] PTR_BX = 2'd0;
    localparam logic [1:0] PTR_BP = 2'd1;

    typedef struct packed {
        logic use_single;
        logic use_base;
        logic use_index;
        logic use_disp;
    } term_en_t;

    function automatic logic mode_legal(input logic [2:0] m);
        return m <= 3'(AM_BASE_REL_IDX);
    endfunction

    function automatic term_en_t decode_terms(input logic [2:0] m);
        term_en_t t;
        t = '0;
        case (m)
            3'(AM_DIRECT):       t.use_disp   = 1'b1;
            3'(AM_REG_IND):      t.use_single = 1'b1;
            3'(AM_BASE_IDX):     begin t.use_base = 1'b1; t.use_index = 1'b1; end
            3'(AM_REG_REL):      begin t.use_single = 1'b1; t.use_disp = 1'b1; end
            3'(AM_BASE_REL_IDX): begin t.use_base = 1'b1; t.use_index = 1'b1; t.use_disp = 1'b1; end
            default:             t = '0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/seg_ea_operand_sel.sv
module seg_ea_operand_sel
    import seg_ea_pkg::*;
#(
    parameter int OFS_W   = 16,
    parameter int SHORT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode,
    input  logic [1:0]       reg_sel,
    input  logic [OFS_W-1:0] bx,
    input  logic [OFS_W-1:0] bp,
    input  logic [OFS_W-1:0] si,
    input  logic [OFS_W-1:0] di,
    input  logic [OFS_W-1:0] disp,
    input  logic             disp_short,
    output logic [OFS_W-1:0] offset,
    output logic             uses_bp
);
    localparam int EXT_W = OFS_W - SHORT_W;

    logic [OFS_W-1:0] disp_ext;
    logic [OFS_W-1:0] ptr [4];
    logic [OFS_W-1:0] single_reg, base_reg, index_reg;
    logic [OFS_W-1:0] t_single, t_base, t_index, t_disp;
    term_en_t         en;

    generate
        if (EXT_W > 0) begin : g_sext
            assign disp_ext = disp_short ? {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]} : disp;
        end else begin : g_nosext
            assign disp_ext = disp;
        end
    endgenerate

    assign ptr[0] = bx;
    assign ptr[1] = bp;
    assign ptr[2] = si;
    assign ptr[3] = di;

    always_comb begin
        en         = decode_terms(mode);
        single_reg = ptr[reg_sel];
        base_reg   = reg_sel[1] ? bp : bx;
        index_reg  = reg_sel[0] ? di : si;
        t_single   = en.use_single ? single_reg : '0;
        t_base     = en.use_base   ? base_reg   : '0;
        t_index    = en.use_index  ? index_reg  : '0;
        t_disp     = en.use_disp   ? disp_ext   : '0;
        offset     = t_single + t_base + t_index + t_disp;
        uses_bp    = (en.use_single && (reg_sel == PTR_BP)) || (en.use_base && reg_sel[1]);
    end

    AST_SINGLE_PTR_TERM: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'(AM_REG_IND)) |-> (offset == bx || offset == bp || offset == si || offset == di)); // R3

    AST_DIRECT_NO_BP: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'(AM_DIRECT)) |-> !uses_bp); // R7

endmodule

// File: rtl/seg_ea_seg_pick.sv
module seg_ea_seg_pick
    import seg_ea_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uses_bp,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_code,
    input  logic [SEG_W-1:0] ds,
    input  logic [SEG_W-1:0] ss,
    input  logic [SEG_W-1:0] es,
    output logic [1:0]       seg_code,
    output logic [SEG_W-1:0] seg_val
);
    logic ovr_ok;

    always_comb begin
        ovr_ok = ovr_en && (ovr_code != 2'(SEG_RSVD));
        if (ovr_ok)       seg_code = ovr_code;
        else if (uses_bp) seg_code = 2'(SEG_SS);
        else              seg_code = 2'(SEG_DS);
        case (seg_code)
            2'(SEG_ES): seg_val = es;
            2'(SEG_SS): seg_val = ss;
            default:    seg_val = ds;
        endcase
    end

    AST_BP_DEFAULTS_SS: assert property (@(posedge clk) disable iff (rst)
        (!(ovr_en && ovr_code != 2'(SEG_RSVD)) && uses_bp) |-> (seg_code == 2'(SEG_SS))); // R7

    AST_OVERRIDE_WINS: assert property (@(posedge clk) disable iff (rst)
        (ovr_en && ovr_code != 2'(SEG_RSVD)) |-> (seg_code == ovr_code)); // R10

    AST_NEVER_RSVD_SEG: assert property (@(posedge clk) disable iff (rst)
        seg_code != 2'(SEG_RSVD)); // R10

endmodule

// File: rtl/seg_ea_phys.sv
module seg_ea_phys #(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PHYS_W    = OFS_W + SEG_SHIFT
) (
    input  logic [OFS_W-1:0]  seg_val,
    input  logic [OFS_W-1:0]  offset,
    output logic [PHYS_W-1:0] phys
);
    logic [PHYS_W-1:0] seg_base;
    logic [PHYS_W-1:0] ofs_wide;

    always_comb begin
        seg_base = {seg_val, {SEG_SHIFT{1'b0}}};
        ofs_wide = {{SEG_SHIFT{1'b0}}, offset};
        phys     = seg_base + ofs_wide;
    end

endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
    import seg_ea_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SHORT_W   = 8,
    parameter int SEG_SHIFT = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [2:0]                 in_mode,
    input  logic [1:0]                 in_reg_sel,
    input  logic [OFS_W-1:0]           in_disp,
    input  logic                       in_disp_short,
    input  logic [OFS_W-1:0]           in_bx,
    input  logic [OFS_W-1:0]           in_bp,
    input  logic [OFS_W-1:0]           in_si,
    input  logic [OFS_W-1:0]           in_di,
    input  logic [OFS_W-1:0]           in_ds,
    input  logic [OFS_W-1:0]           in_ss,
    input  logic [OFS_W-1:0]           in_es,
    input  logic                       in_ovr_en,
    input  logic [1:0]                 in_ovr_seg,
    output logic                       out_valid,
    output logic [OFS_W-1:0]           out_offset,
    output logic [1:0]                 out_seg,
    output logic [OFS_W-1:0]           out_seg_val,
    output logic [OFS_W+SEG_SHIFT-1:0] out_phys
);
    localparam int PHYS_W = OFS_W + SEG_SHIFT;

    logic [OFS_W-1:0]  ofs_c;
    logic              bp_c;
    logic [1:0]        seg_c;
    logic [OFS_W-1:0]  segv_c;
    logic [PHYS_W-1:0] phys_c;
    logic              accept;

    seg_ea_operand_sel #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_ops (
        .clk        (clk),
        .rst        (rst),
        .mode       (in_mode),
        .reg_sel    (in_reg_sel),
        .bx         (in_bx),
        .bp         (in_bp),
        .si         (in_si),
        .di         (in_di),
        .disp       (in_disp),
        .disp_short (in_disp_short),
        .offset     (ofs_c),
        .uses_bp    (bp_c)
    );

    seg_ea_seg_pick #(.SEG_W(OFS_W)) u_seg (
        .clk      (clk),
        .rst      (rst),
        .uses_bp  (bp_c),
        .ovr_en   (in_ovr_en),
        .ovr_code (in_ovr_seg),
        .ds       (in_ds),
        .ss       (in_ss),
        .es       (in_es),
        .seg_code (seg_c),
        .seg_val  (segv_c)
    );

    seg_ea_phys #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .PHYS_W(PHYS_W)) u_phys (
        .seg_val (segv_c),
        .offset  (ofs_c),
        .phys    (phys_c)
    );

    assign accept = in_valid && mode_legal(in_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_offset  <= '0;
            out_seg     <= '0;
            out_seg_val <= '0;
            out_phys    <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_offset  <= ofs_c;
                out_seg     <= seg_c;
                out_seg_val <= segv_c;
                out_phys    <= phys_c;
            end
        end
    end

    AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid); // R12

    AST_RSVD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_legal(in_mode)) |=> !out_valid); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(out_offset) && $stable(out_phys) && $stable(out_seg))); // R12

    AST_DIRECT_DISP: assert property (@(posedge clk) disable iff (rst)
        (accept && in_mode == 3'(AM_DIRECT) && !in_disp_short) |=> (out_offset == $past(in_disp))); // R2

    AST_PHYS_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_phys[SEG_SHIFT-1:0] == out_offset[SEG_SHIFT-1:0])); // R1

endmodule

// File: tb/seg_ea_gen_tb.sv
`timescale 1ns/1ps
module seg_ea_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_mode = '0;
    logic [1:0]  in_reg_sel = '0;
    logic [15:0] in_disp = '0;
    logic        in_disp_short = 1'b0;
    logic [15:0] in_bx = '0, in_bp = '0, in_si = '0, in_di = '0;
    logic [15:0] in_ds = '0, in_ss = '0, in_es = '0;
    logic        in_ovr_en = 1'b0;
    logic [1:0]  in_ovr_seg = '0;
    logic        out_valid;
    logic [15:0] out_offset;
    logic [1:0]  out_seg;
    logic [15:0] out_seg_val;
    logic [19:0] out_phys;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] q_ofs  [$];
    logic [1:0]  q_seg  [$];
    logic [19:0] q_phys [$];
    string       q_tag  [$];

    always #2 clk = ~clk;

    seg_ea_gen u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_reg_sel(in_reg_sel), .in_disp(in_disp), .in_disp_short(in_disp_short),
        .in_bx(in_bx), .in_bp(in_bp), .in_si(in_si), .in_di(in_di),
        .in_ds(in_ds), .in_ss(in_ss), .in_es(in_es),
        .in_ovr_en(in_ovr_en), .in_ovr_seg(in_ovr_seg),
        .out_valid(out_valid), .out_offset(out_offset), .out_seg(out_seg),
        .out_seg_val(out_seg_val), .out_phys(out_phys)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model from the requirements
    task automatic model(output logic [15:0] ofs, output logic [1:0] seg, output logic [19:0] phys);
        logic [15:0] d, b, x, p, sv;
        logic        bpu;
        d   = in_disp_short ? {{8{in_disp[7]}}, in_disp[7:0]} : in_disp;
        b   = in_reg_sel[1] ? in_bp : in_bx;
        x   = in_reg_sel[0] ? in_di : in_si;
        case (in_reg_sel)
            2'd0: p = in_bx;
            2'd1: p = in_bp;
            2'd2: p = in_si;
            default: p = in_di;
        endcase
        bpu = 1'b0;
        case (in_mode)
            3'd0: ofs = d;
            3'd1: begin ofs = p; bpu = (in_reg_sel == 2'd1); end
            3'd2: begin ofs = b + x; bpu = in_reg_sel[1]; end
            3'd3: begin ofs = p + d; bpu = (in_reg_sel == 2'd1); end
            default: begin ofs = b + x + d; bpu = in_reg_sel[1]; end
        endcase
        if (in_ovr_en && in_ovr_seg != 2'd3) seg = in_ovr_seg;
        else seg = bpu ? 2'd1 : 2'd2;
        sv   = (seg == 2'd0) ? in_es : (seg == 2'd1) ? in_ss : in_ds;
        phys = 20'({sv, 4'h0} + {4'h0, ofs});
    endtask

    task automatic drive(input logic [2:0] m, input logic [1:0] sel, input logic [15:0] d,
                         input bit sh, input bit oe, input logic [1:0] os, input string tag);
        logic [15:0] eo;
        logic [1:0]  es_;
        logic [19:0] ep;
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_reg_sel = sel; in_disp = d;
        in_disp_short = sh; in_ovr_en = oe; in_ovr_seg = os;
        if (m <= 3'd4) begin
            model(eo, es_, ep);
            q_ofs.push_back(eo); q_seg.push_back(es_); q_phys.push_back(ep); q_tag.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done && out_valid) begin
            if (q_ofs.size() == 0) begin
                chk(1'b0, "R11 unexpected out_valid", 64'(out_offset), 64'h0);
            end else begin
                logic [15:0] eo;
                logic [1:0]  es_;
                logic [19:0] ep;
                string       t;
                eo = q_ofs.pop_front(); es_ = q_seg.pop_front();
                ep = q_phys.pop_front(); t = q_tag.pop_front();
                chk({out_offset, out_seg, out_phys} == {eo, es_, ep}, t,
                    64'({out_offset, out_seg, out_phys}), 64'({eo, es_, ep}));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog expired", 64'h0, 64'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] h_ofs;
        logic [19:0] h_phys;
        logic [1:0]  h_seg;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13: reset state
        chk(out_valid == 1'b0, "R13 valid after reset", 64'(out_valid), 64'h0);
        chk({out_offset, out_seg, out_seg_val, out_phys} == '0, "R13 outputs after reset",
            64'({out_offset, out_seg, out_seg_val, out_phys}), 64'h0);

        // R5: worked example, offset 1100h, physical 03100h
        in_ds = 16'h0200; in_bx = 16'h0100; in_ss = 16'h3000; in_es = 16'h5000;
        in_bp = 16'h0040; in_si = 16'h0006; in_di = 16'h0222;
        drive(3'd3, 2'd0, 16'h1000, 0, 0, 2'd0, "R5 pointer relative example");
        @(negedge clk); in_valid = 1'b0;
        chk(out_phys == 20'h03100, "R5 physical 03100h", 64'(out_phys), 64'h03100);
        // R12: strobe only for one cycle
        @(negedge clk);
        chk(out_valid == 1'b0, "R12 strobe single cycle", 64'(out_valid), 64'h0);

        // R2: direct, back-to-back with other forms
        in_ds = 16'h4321;
        drive(3'd0, 2'd3, 16'h1234, 0, 0, 2'd0, "R2 direct DS");
        // R3: each single pointer, R7 BP selects SS
        for (int k = 0; k < 4; k++) drive(3'd1, 2'(k), 16'hAAAA, 0, 0, 2'd0, "R3/R7 single pointer");
        // R4: all base/index pairs
        for (int k = 0; k < 4; k++) drive(3'd2, 2'(k), 16'h0000, 0, 0, 2'd0, "R4/R7 base plus index");
        // R6: base relative plus index
        for (int k = 0; k < 4; k++) drive(3'd4, 2'(k), 16'h0300, 0, 0, 2'd0, "R6 base rel index");
        // R8: short displacement sign-extended (80h -> FF80h)
        drive(3'd3, 2'd0, 16'h5580, 1, 0, 2'd0, "R8 short negative disp");
        drive(3'd4, 2'd1, 16'hEE7F, 1, 0, 2'd0, "R8 short positive disp");
        drive(3'd0, 2'd0, 16'h00FE, 1, 0, 2'd0, "R8 short direct");
        idle(2);

        // R9: offset wraps
        in_bx = 16'hFFFF; in_si = 16'h0002; in_ds = 16'h1000;
        drive(3'd2, 2'd0, 16'h0000, 0, 0, 2'd0, "R9 offset wrap");
        @(negedge clk); in_valid = 1'b0;
        chk(out_offset == 16'h0001, "R9 wrapped offset", 64'(out_offset), 64'h1);

        // R1: physical wrap FFFFh:FFFFh -> 0FFEFh
        in_ds = 16'hFFFF;
        drive(3'd0, 2'd0, 16'hFFFF, 0, 0, 2'd0, "R1 physical wrap");
        @(negedge clk); in_valid = 1'b0;
        chk(out_phys == 20'h0FFEF, "R1 physical wrap value", 64'(out_phys), 64'h0FFEF);

        // R10: overrides, including ignored code 3
        in_ds = 16'h0100; in_ss = 16'h0200; in_es = 16'h0300; in_bp = 16'h0010; in_bx = 16'h0020;
        drive(3'd1, 2'd1, 16'h0, 0, 1, 2'd0, "R10 ES override on BP");
        drive(3'd1, 2'd0, 16'h0, 0, 1, 2'd1, "R10 SS override on BX");
        drive(3'd2, 2'd2, 16'h0, 0, 1, 2'd2, "R10 DS override on BP base");
        drive(3'd1, 2'd1, 16'h0, 0, 1, 2'd3, "R10 code 3 ignored");
        @(negedge clk); in_valid = 1'b0;
        chk(out_seg == 2'd1, "R10 code 3 keeps SS default", 64'(out_seg), 64'h1);
        idle(1);

        // R11: reserved codes produce nothing and keep outputs
        h_ofs = out_offset; h_phys = out_phys; h_seg = out_seg;
        for (int k = 5; k < 8; k++) begin
            drive(3'(k), 2'd0, 16'h1357, 0, 0, 2'd0, "R11 reserved");
            @(negedge clk); in_valid = 1'b0;
            chk(out_valid == 1'b0, "R11 no strobe for reserved", 64'(out_valid), 64'h0);
            chk({out_offset, out_seg, out_phys} == {h_ofs, h_seg, h_phys}, "R11 outputs kept",
                64'({out_offset, out_seg, out_phys}), 64'({h_ofs, h_seg, h_phys}));
        end

        // R12: outputs hold while idle and inputs change
        in_bx = 16'h0AB0; in_ds = 16'h0777;
        drive(3'd1, 2'd0, 16'h0, 0, 0, 2'd0, "R12 last request");
        @(negedge clk); in_valid = 1'b0;
        h_ofs = out_offset; h_phys = out_phys; h_seg = out_seg;
        in_bx = 16'h9999; in_bp = 16'h8888; in_ds = 16'h1111; in_ss = 16'h2222;
        in_mode = 3'd4; in_reg_sel = 2'd3; in_ovr_en = 1'b1; in_ovr_seg = 2'd0;
        idle(3);
        chk({out_offset, out_seg, out_phys} == {h_ofs, h_seg, h_phys}, "R12 hold while idle",
            64'({out_offset, out_seg, out_phys}), 64'({h_ofs, h_seg, h_phys}));
        chk(out_valid == 1'b0, "R12 no strobe while idle", 64'(out_valid), 64'h0);
        chk(q_ofs.size() == 0, "R12 every request answered", 64'(q_ofs.size()), 64'h0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule